// File: doc/BRIEF.md
# Remote Clock Offset Estimator

This block keeps track of how far a remote gateway's free-running clock sits from the local time base. On a programmable interval it sends a timestamp request to the gateway. It records the local time when the gateway accepts the request and again when the reply arrives. It treats the gateway's returned stamp as if it had been taken exactly halfway between those two local instants, which assumes the outbound and return paths take equal time. From that it derives a single offset. The offset is updated only when the round trip is short enough to be trusted.

The gateway also sends completion notices for frames it has finished sending or receiving. Each notice carries a gateway timestamp. The block adds the stored offset to that timestamp and reports the result in local time. A time master uses the transmit-side result as the completion time of its synchronization frame. A time slave uses the receive-side result as the arrival time of that frame. Until the first trusted measurement exists, results are passed through unchanged and marked as untranslated.

Top module: `rco_estimator`

## Requirements
- R1: While reset is asserted, `req_valid`, `out_valid` and `offset_valid` are low.
- R2: Once reset is released, a request is raised at once. After that, a request rises every `period_cfg` cycles, counted from the previous rising edge, provided each exchange finishes inside that window. A `period_cfg` of 0 behaves as 1.
- R3: `req_valid` stays high until `req_ready` is seen. The local time in the accepting cycle is taken as ts1.
- R4: A response (`rsp_valid` while waiting) sets ts2 to the local time of that cycle and ts0 to `rsp_stamp`. If ts2−ts1 ≤ `rtt_limit`, the offset becomes ts1 + ((ts2−ts1) >> 1) − ts0 and `offset_valid` rises. It then stays high until reset.
- R5: A response whose round trip ts2−ts1 exceeds `rtt_limit` is discarded. The previous offset and `offset_valid` are kept.
- R6: One cycle after `cnf_valid`, `out_valid` pulses for one cycle. In that cycle `out_time` = `cnf_stamp` + offset and `out_dir` = `cnf_dir`, where 0 means transmit completion and 1 means receive completion.
- R7: A confirmation that arrives while `offset_valid` is low gives `out_translated` = 0 and `out_time` = `cnf_stamp` unchanged. Otherwise `out_translated` = 1.
- R8: `rsp_valid` has no effect when no request has been accepted and left waiting for a reply.
- R9: All time arithmetic is modulo 2^32, including round trips that wrap the local counter and offsets that are negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| local_time | input | 32 | Local time base |
| period_cfg | input | 16 | Measurement interval in cycles |
| rtt_limit | input | 32 | Largest accepted round trip |
| req_valid | output | 1 | Timestamp request to gateway |
| req_ready | input | 1 | Gateway accepts request |
| rsp_valid | input | 1 | Gateway reply present |
| rsp_stamp | input | 32 | Gateway timestamp ts0 |
| cnf_valid | input | 1 | Completion notice present |
| cnf_dir | input | 1 | 0 transmit, 1 receive |
| cnf_stamp | input | 32 | Gateway completion timestamp |
| out_valid | output | 1 | Translated result present |
| out_dir | output | 1 | Direction of the result |
| out_time | output | 32 | Completion time in local time |
| out_translated | output | 1 | Offset was applied |
| offset_valid | output | 1 | A trusted offset exists |

## Verification
The hardest case to reach is a rejected measurement that follows an accepted one. The only visible sign is that later confirmations still use the old offset. The bench first runs a table of exchanges with chosen ts1, ts2 and ts0, including wrapped and odd round trips. It then runs an exchange one cycle over the bound and checks a confirmation against the earlier offset. The request interval is checked by shortening `period_cfg` and timing two consecutive request edges once a full interval has started under the new value.

// File: rtl/rco_pkg.sv
package rco_pkg;
  typedef enum logic [1:0] {XS_IDLE, XS_REQ, XS_WAIT} xstate_t;
  localparam logic DIR_TX = 1'b0;
  localparam logic DIR_RX = 1'b1;
endpackage

// File: rtl/rco_period_timer.sv
module rco_period_timer #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] period,
  output logic          tick
);
  logic [PW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] reload;

  always_comb begin
    reload = (period == '0) ? '0 : period - 1'b1;
    tick   = (cnt_q == '0);
    cnt_d  = tick ? reload : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2
  reload_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q <= $past(period)));
endmodule

// File: rtl/rco_exchange.sv
module rco_exchange
  import rco_pkg::*;
#(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [TW-1:0] local_time,
  input  logic [TW-1:0] rtt_limit,
  output logic          req_valid,
  input  logic          req_ready,
  input  logic          rsp_valid,
  input  logic [TW-1:0] rsp_stamp,
  output logic [TW-1:0] offset,
  output logic          offset_valid
);
  xstate_t       state_q, state_d;
  logic [TW-1:0] ts1_q, ts1_d;
  logic [TW-1:0] off_q, off_d;
  logic          ovld_q, ovld_d;
  logic [TW-1:0] rtt, mid;
  logic          accept;

  always_comb begin
    state_d = state_q;
    ts1_d   = ts1_q;
    off_d   = off_q;
    ovld_d  = ovld_q;
    rtt     = local_time - ts1_q;
    mid     = ts1_q + (rtt >> 1);
    accept  = (rtt <= rtt_limit);
    unique case (state_q)
      XS_IDLE: if (start) state_d = XS_REQ;
      XS_REQ: if (req_ready) begin
        ts1_d   = local_time;
        state_d = XS_WAIT;
      end
      XS_WAIT: if (rsp_valid) begin
        state_d = XS_IDLE;
        if (accept) begin
          off_d  = mid - rsp_stamp;
          ovld_d = 1'b1;
        end
      end
      default: state_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
      ts1_q   <= '0;
      off_q   <= '0;
      ovld_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ts1_q   <= ts1_d;
      off_q   <= off_d;
      ovld_q  <= ovld_d;
    end
  end

  assign req_valid    = (state_q == XS_REQ);
  assign offset       = off_q;
  assign offset_valid = ovld_q;

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> req_valid);
  // R4
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    offset_valid |=> offset_valid);
  // R8
  stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != XS_WAIT) |=> ($stable(off_q) && $stable(ovld_q)));
endmodule

// File: rtl/rco_translator.sv
module rco_translator #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnf_valid,
  input  logic          cnf_dir,
  input  logic [TW-1:0] cnf_stamp,
  input  logic [TW-1:0] offset,
  input  logic          offset_valid,
  output logic          out_valid,
  output logic          out_dir,
  output logic [TW-1:0] out_time,
  output logic          out_translated
);
  logic [TW-1:0] time_d;

  always_comb begin
    time_d = offset_valid ? cnf_stamp + offset : cnf_stamp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_dir        <= 1'b0;
      out_time       <= '0;
      out_translated <= 1'b0;
    end else begin
      out_valid <= cnf_valid;
      if (cnf_valid) begin
        out_dir        <= cnf_dir;
        out_time       <= time_d;
        out_translated <= offset_valid;
      end
    end
  end

  // R6
  out_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnf_valid |=> out_valid);
  // R6
  out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnf_valid |=> !out_valid);
  // R7
  raw_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_translated) |-> (out_time == $past(cnf_stamp)));
endmodule

// File: rtl/rco_estimator.sv
module rco_estimator #(
  parameter int TW = 32,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] local_time,
  input  logic [PW-1:0] period_cfg,
  input  logic [TW-1:0] rtt_limit,
  output logic          req_valid,
  input  logic          req_ready,
  input  logic          rsp_valid,
  input  logic [TW-1:0] rsp_stamp,
  input  logic          cnf_valid,
  input  logic          cnf_dir,
  input  logic [TW-1:0] cnf_stamp,
  output logic          out_valid,
  output logic          out_dir,
  output logic [TW-1:0] out_time,
  output logic          out_translated,
  output logic          offset_valid
);
  logic          tick;
  logic [TW-1:0] offset;

  rco_period_timer #(.PW(PW)) u_timer (
    .clk(clk), .rst_n(rst_n), .period(period_cfg), .tick(tick)
  );

  rco_exchange #(.TW(TW)) u_xchg (
    .clk(clk), .rst_n(rst_n), .start(tick), .local_time(local_time),
    .rtt_limit(rtt_limit), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_stamp(rsp_stamp),
    .offset(offset), .offset_valid(offset_valid)
  );

  rco_translator #(.TW(TW)) u_xlat (
    .clk(clk), .rst_n(rst_n), .cnf_valid(cnf_valid), .cnf_dir(cnf_dir),
    .cnf_stamp(cnf_stamp), .offset(offset), .offset_valid(offset_valid),
    .out_valid(out_valid), .out_dir(out_dir), .out_time(out_time),
    .out_translated(out_translated)
  );
endmodule

// File: tb/rco_estimator_tb.sv
module rco_estimator_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 4;
  // each entry: {ts1, ts2, ts0, confirmation stamp}
  localparam logic [127:0] VEC [NV] = '{
    {32'd100,        32'd140,        32'd5000, 32'd6000},
    {32'd1000,       32'd1003,       32'd1,    32'hFFFF_FFF0},
    {32'hFFFF_FFF0,  32'h0000_0010,  32'h10,   32'h20},
    {32'd0,          32'd1000,       32'd200,  32'd7}
  };

  logic        clk = 0, rst_n = 0;
  logic [31:0] local_time = 0, rtt_limit = 32'd1000, rsp_stamp = 0, cnf_stamp = 0;
  logic [15:0] period_cfg = 16'd1000;
  logic        req_ready = 0, rsp_valid = 0, cnf_valid = 0, cnf_dir = 0;
  logic        req_valid, out_valid, out_dir, out_translated, offset_valid;
  logic [31:0] out_time;
  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] exp_off;

  rco_estimator u_dut (
    .clk(clk), .rst_n(rst_n), .local_time(local_time), .period_cfg(period_cfg),
    .rtt_limit(rtt_limit), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_stamp(rsp_stamp), .cnf_valid(cnf_valid),
    .cnf_dir(cnf_dir), .cnf_stamp(cnf_stamp), .out_valid(out_valid),
    .out_dir(out_dir), .out_time(out_time), .out_translated(out_translated),
    .offset_valid(offset_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] calc_off(logic [31:0] t1, logic [31:0] t2, logic [31:0] t0);
    logic [31:0] d = t2 - t1;
    return t1 + (d >> 1) - t0;
  endfunction

  task automatic wait_req();
    while (!req_valid) @(negedge clk);
  endtask

  task automatic exchange(input logic [31:0] t1, input logic [31:0] t2, input logic [31:0] t0);
    wait_req();
    local_time = t1; req_ready = 1;
    @(negedge clk);
    req_ready = 0; local_time = t2; rsp_valid = 1; rsp_stamp = t0;
    @(negedge clk);
    rsp_valid = 0;
  endtask

  task automatic confirm(input logic d, input logic [31:0] s);
    cnf_valid = 1; cnf_dir = d; cnf_stamp = s;
    @(negedge clk);
    cnf_valid = 0;
  endtask

  initial begin
    wait (cyc == 100000);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=<100000", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 req_valid", req_valid, 0);
    check("R1 out_valid", out_valid, 0);
    check("R1 offset_valid", offset_valid, 0);
    rst_n = 1;
    @(negedge clk);
    // R2 first request right after reset
    check("R2 first request", req_valid, 1);
    // R8 response while request not yet accepted is ignored
    rsp_valid = 1; rsp_stamp = 32'h55; @(negedge clk); rsp_valid = 0;
    check("R8 no offset from stray rsp", offset_valid, 0);
    // R7 untranslated pass-through
    confirm(1'b1, 32'h1234_5678);
    check("R7 out_valid", out_valid, 1);
    check("R7 untranslated flag", out_translated, 0);
    check("R7 raw time", out_time, 32'h1234_5678);
    check("R3 request still held", req_valid, 1);

    // table: R4, R6, R9
    for (int i = 0; i < NV; i++) begin
      logic [31:0] t1 = VEC[i][127:96], t2 = VEC[i][95:64];
      logic [31:0] t0 = VEC[i][63:32], st = VEC[i][31:0];
      exchange(t1, t2, t0);
      exp_off = calc_off(t1, t2, t0);
      check("R4 offset_valid", offset_valid, 1);
      confirm(i[0], st);
      check("R6 out_valid", out_valid, 1);
      check("R6 out_dir", out_dir, i[0]);
      check("R7 translated flag", out_translated, 1);
      check("R4 R9 out_time", out_time, st + exp_off);
      @(negedge clk);
      check("R6 single pulse", out_valid, 0);
    end

    // R5 round trip one over the limit: offset unchanged
    exchange(32'd0, 32'd1001, 32'd0);
    confirm(1'b0, 32'd7);
    check("R5 old offset kept", out_time, 32'd7 + exp_off);
    check("R5 still valid", offset_valid, 1);

    // R8 response while idle after an exchange
    rsp_valid = 1; rsp_stamp = 32'h9999; local_time = 32'd3; @(negedge clk); rsp_valid = 0;
    confirm(1'b1, 32'd50);
    check("R8 idle rsp ignored", out_time, 32'd50 + exp_off);

    // R2 interval
    period_cfg = 16'd20;
    exchange(32'd10, 32'd12, 32'd0);
    exp_off = calc_off(32'd10, 32'd12, 32'd0);
    begin
      int c0;
      wait_req();
      c0 = cyc;
      exchange(32'd20, 32'd22, 32'd0);
      wait_req();
      check("R2 request interval", cyc - c0, 20);
    end
    exp_off = calc_off(32'd20, 32'd22, 32'd0);
    confirm(1'b0, 32'd0);
    check("R4 small rtt offset", out_time, exp_off);

    // R1 reset mid-operation clears state
    rst_n = 0; @(negedge clk);
    check("R1 reset clears offset_valid", offset_valid, 0);
    check("R1 reset clears req", req_valid, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule